// File: doc/BRIEF.md
# Bit-Sliced Arithmetic Logic Unit with Signed Compare

This block is a purely combinational arithmetic logic unit for two operands of `WIDTH` bits (32 by default). It is assembled from one-bit slices that each hold an operand inverter pair, an AND gate, an OR gate and a full adder. The slices are chained by their carries, starting at bit 0 and ending at the top bit. The top bit uses a dedicated slice. That slice also works out the signed overflow and the signed-compare bit, and the compare bit is routed back into bit 0 of the result.

A single 4-bit control word drives every slice. Bit 3 inverts operand A. Bit 2 inverts operand B and also sets the carry into bit 0 to 1. Bits 1:0 pick the slice output. Through these controls one datapath provides AND, OR, NOR, add, subtract and signed set-on-less-than. Alongside the result, the block reports a zero flag and a signed overflow flag.

Top module: `slice_alu`

## Requirements
- R1: Control 4'b0000 makes `result` equal to `opnd_a & opnd_b`.
- R2: Control 4'b0001 makes `result` equal to `opnd_a | opnd_b`.
- R3: Control 4'b0010 makes `result` equal to `(opnd_a + opnd_b) mod 2^WIDTH`.
- R4: Control 4'b0110 makes `result` equal to `(opnd_a - opnd_b) mod 2^WIDTH`.
- R5: Control 4'b0111 sets `result[0]` to 1 exactly when `opnd_a < opnd_b` as two's complement numbers, and clears every other result bit. This holds even when the internal subtraction overflows.
- R6: Control 4'b1100 makes `result` equal to `~(opnd_a | opnd_b)`.
- R7: For every control value, `zero` is 1 exactly when all bits of `result` are 0.
- R8: `ovf` is 1 exactly when the signed sum of the slice adder overflows, that is, when the carry into the top bit differs from the carry out of it. For add, this means both operands share a sign and the result does not. For subtract, it means the operands differ in sign and the result sign differs from that of `opnd_a`.
- R9: Every one of the 16 control values acts field by field. Bit 3 inverts A. Bit 2 inverts B and forces the bit-0 carry-in to 1. Bits 1:0 select 00 AND, 01 OR, 10 sum, 11 compare. The compare bit is the sign of the exact sum of the two possibly inverted operands plus the carry-in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| ctrl | input | 4 | {invert A, negate B, select[1:0]} |
| result | output | WIDTH | Function result |
| zero | output | 1 | High when result is all zero |
| ovf | output | 1 | Signed overflow of the slice adder |

## Verification
The block holds no state, so a fault inside it shows at the ports in the same evaluation as the inputs that provoke it. A broken carry link between two slices corrupts the sum for any operand pair that produces a carry at that link. It also corrupts the compare and overflow bits whenever that carry reaches the top slice. At four bits, every operand pair under all sixteen control codes is applied, so every carry link and every compare case is exercised. At 32 bits, edge values and pseudo-random pairs catch faults that only appear at the full width.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [1:0] {
      SEL_AND  = 2'b00,
      SEL_OR   = 2'b01,
      SEL_SUM  = 2'b10,
      SEL_LESS = 2'b11
   } sel_e;

   typedef struct packed {
      logic inv_a;
      logic neg_b;
      sel_e sel;
   } ctrl_t;

   localparam logic [3:0] CODE_AND = 4'b0000;
   localparam logic [3:0] CODE_OR  = 4'b0001;
   localparam logic [3:0] CODE_ADD = 4'b0010;
   localparam logic [3:0] CODE_SUB = 4'b0110;
   localparam logic [3:0] CODE_SLT = 4'b0111;
   localparam logic [3:0] CODE_NOR = 4'b1100;

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
   import alu_pkg::*;
(
   input  logic a,
   input  logic b,
   input  logic inv_a,
   input  logic inv_b,
   input  logic cin,
   input  logic less,
   input  sel_e sel,
   output logic res,
   output logic cout
);

   logic aa;
   logic bb;
   logic sum;

   assign aa   = a ^ inv_a;
   assign bb   = b ^ inv_b;
   assign sum  = aa ^ bb ^ cin;
   assign cout = (aa & bb) | (cin & (aa ^ bb));

   always_comb begin
      unique case (sel)
         SEL_AND:  res = aa & bb;
         SEL_OR:   res = aa | bb;
         SEL_SUM:  res = sum;
         SEL_LESS: res = less;
         default:  res = 1'b0;
      endcase
   end

endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
   import alu_pkg::*;
(
   input  logic a,
   input  logic b,
   input  logic inv_a,
   input  logic inv_b,
   input  logic cin,
   input  logic less,
   input  sel_e sel,
   output logic res,
   output logic set,
   output logic ovf
);

   logic aa;
   logic bb;
   logic sum;
   logic cout;

   assign aa   = a ^ inv_a;
   assign bb   = b ^ inv_b;
   assign sum  = aa ^ bb ^ cin;
   assign cout = (aa & bb) | (cin & (aa ^ bb));

   // signed overflow: carry entering the top bit disagrees with carry leaving it
   assign ovf  = cin ^ cout;
   // true sign of the exact sum, corrected for overflow
   assign set  = sum ^ ovf;

   always_comb begin
      unique case (sel)
         SEL_AND:  res = aa & bb;
         SEL_OR:   res = aa | bb;
         SEL_SUM:  res = sum;
         SEL_LESS: res = less;
         default:  res = 1'b0;
      endcase
   end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] vec,
   output logic             is_zero
);

   generate
      if (WIDTH < 1) begin : g_chk
         $error("alu_zero_detect: WIDTH must be at least 1");
      end
   endgenerate

   assign is_zero = ~|vec;

endmodule

// File: rtl/slice_alu.sv
module slice_alu
   import alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic [3:0]       ctrl,
   output logic [WIDTH-1:0] result,
   output logic             zero,
   output logic             ovf
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_chk
         $error("slice_alu: WIDTH must be at least 2");
      end
   endgenerate

   ctrl_t            cf;
   logic [MSB:0]     cin_v;
   logic [MSB-1:0]   cout_v;
   logic             set_bit;

   assign cf       = ctrl_t'(ctrl);
   assign cin_v[0] = cf.neg_b;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         if (i > 0) begin : g_link
            assign cin_v[i] = cout_v[i-1];
         end
         if (i < MSB) begin : g_std
            alu_bit_slice u_slice (
               .a     (opnd_a[i]),
               .b     (opnd_b[i]),
               .inv_a (cf.inv_a),
               .inv_b (cf.neg_b),
               .cin   (cin_v[i]),
               .less  ((i == 0) ? set_bit : 1'b0),
               .sel   (cf.sel),
               .res   (result[i]),
               .cout  (cout_v[i])
            );
         end else begin : g_top
            alu_msb_slice u_slice (
               .a     (opnd_a[i]),
               .b     (opnd_b[i]),
               .inv_a (cf.inv_a),
               .inv_b (cf.neg_b),
               .cin   (cin_v[i]),
               .less  (1'b0),
               .sel   (cf.sel),
               .res   (result[i]),
               .set   (set_bit),
               .ovf   (ovf)
            );
         end
      end
   endgenerate

   alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
      .vec     (result),
      .is_zero (zero)
   );

endmodule

// File: rtl/slice_alu_chk.sv
module slice_alu_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] opnd_a,
   input logic [WIDTH-1:0] opnd_b,
   input logic [3:0]       ctrl,
   input logic [WIDTH-1:0] result,
   input logic             zero,
   input logic             ovf
);

   localparam int MSB = WIDTH - 1;

   always_comb begin
      if (ctrl == 4'b0000) begin
         AST_AND_MATCH: assert (result == (opnd_a & opnd_b)); // R1
      end
      if (ctrl == 4'b0001) begin
         AST_OR_MATCH: assert (result == (opnd_a | opnd_b)); // R2
      end
      if (ctrl == 4'b0010) begin
         AST_ADD_MATCH: assert (result == opnd_a + opnd_b); // R3
         AST_ADD_OVF: assert (ovf == ((opnd_a[MSB] == opnd_b[MSB]) && (result[MSB] != opnd_a[MSB]))); // R8
      end
      if (ctrl == 4'b0110) begin
         AST_SUB_MATCH: assert (result == opnd_a - opnd_b); // R4
         AST_SUB_OVF: assert (ovf == ((opnd_a[MSB] != opnd_b[MSB]) && (result[MSB] != opnd_a[MSB]))); // R8
      end
      if (ctrl == 4'b0111) begin
         AST_SLT_MATCH: assert ((result[0] == ($signed(opnd_a) < $signed(opnd_b))) && (result[MSB:1] == '0)); // R5
      end
      if (ctrl == 4'b1100) begin
         AST_NOR_MATCH: assert (result == ~(opnd_a | opnd_b)); // R6
      end
      AST_ZERO_FLAG: assert (zero == (result == '0)); // R7
   end

endmodule

bind slice_alu slice_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .opnd_a (opnd_a),
   .opnd_b (opnd_b),
   .ctrl   (ctrl),
   .result (result),
   .zero   (zero),
   .ovf    (ovf)
);

// File: tb/slice_alu_tb.sv
module slice_alu_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   int vectors = 0;
   int misses  = 0;
   bit done    = 1'b0;

   logic [3:0]  a4, b4, c4;
   logic [3:0]  r4;
   logic        z4, o4;
   logic [31:0] a32, b32;
   logic [3:0]  c32;
   logic [31:0] r32;
   logic        z32, o32;

   slice_alu #(.WIDTH(4)) u_dut (
      .opnd_a(a4), .opnd_b(b4), .ctrl(c4),
      .result(r4), .zero(z4), .ovf(o4)
   );

   slice_alu #(.WIDTH(32)) u_dut32 (
      .opnd_a(a32), .opnd_b(b32), .ctrl(c32),
      .result(r32), .zero(z32), .ovf(o32)
   );

   function automatic string tag_of(input logic [3:0] c);
      case (c)
         4'b0000: return "R1";
         4'b0001: return "R2";
         4'b0010: return "R3";
         4'b0110: return "R4";
         4'b0111: return "R5";
         4'b1100: return "R6";
         default: return "R9";
      endcase
   endfunction

   // expected {ovf, zero, result} from field-wise arithmetic
   function automatic logic [65:0] model(input int w, input logic [63:0] a,
                                         input logic [63:0] b, input logic [3:0] c);
      logic [63:0] mask, sb, x, y, s, r;
      longint xv, yv, full;
      logic cin, of, st;
      mask = (64'd1 << w) - 64'd1;
      sb   = 64'd1 << (w - 1);
      x    = (c[3] ? ~a : a) & mask;
      y    = (c[2] ? ~b : b) & mask;
      cin  = c[2];
      s    = (x + y + {63'd0, cin}) & mask;
      of   = ((x & sb) == (y & sb)) && ((s & sb) != (x & sb));
      xv   = ((x & sb) != 0) ? longint'(x) - longint'(64'd1 << w) : longint'(x);
      yv   = ((y & sb) != 0) ? longint'(y) - longint'(64'd1 << w) : longint'(y);
      full = xv + yv + longint'(cin);
      st   = (full < 0);
      case (c[1:0])
         2'b00:   r = x & y;
         2'b01:   r = x | y;
         2'b10:   r = s;
         default: r = {63'd0, st};
      endcase
      return {of, (r == 64'd0), r};
   endfunction

   task automatic compare(input int w, input logic [63:0] a, input logic [63:0] b,
                          input logic [3:0] c, input logic [63:0] got_r,
                          input logic got_z, input logic got_o);
      logic [65:0] e;
      bit bad;
      e = model(w, a, b, c);
      bad = 1'b0;
      vectors++;
      if (got_r != e[63:0]) begin
         bad = 1'b1;
         $display("FAIL %s w=%0d ctrl=%b a=%h b=%h result=%h expected=%h",
                  tag_of(c), w, c, a, b, got_r, e[63:0]);
      end
      if (got_z != e[64]) begin
         bad = 1'b1;
         $display("FAIL R7 w=%0d ctrl=%b a=%h b=%h zero=%b expected=%b",
                  w, c, a, b, got_z, e[64]);
      end
      if (got_o != e[65]) begin
         bad = 1'b1;
         $display("FAIL R8 w=%0d ctrl=%b a=%h b=%h ovf=%b expected=%b",
                  w, c, a, b, got_o, e[65]);
      end
      if (bad) misses++;
   endtask

   task automatic apply4(input logic [3:0] a, input logic [3:0] b, input logic [3:0] c);
      @(negedge clk);
      a4 = a; b4 = b; c4 = c;
      #1;
      compare(4, {60'd0, a}, {60'd0, b}, c, {60'd0, r4}, z4, o4);
   endtask

   task automatic apply32(input logic [31:0] a, input logic [31:0] b, input logic [3:0] c);
      @(negedge clk);
      a32 = a; b32 = b; c32 = c;
      #1;
      compare(32, {32'd0, a}, {32'd0, b}, c, {32'd0, r32}, z32, o32);
   endtask

   logic [31:0] edges [8];

   initial begin
      logic [31:0] lfsr;
      a4 = '0; b4 = '0; c4 = '0;
      a32 = '0; b32 = '0; c32 = '0;
      repeat (3) @(posedge clk);
      // idle inputs during reset: result 0, zero flag high (R7)
      @(negedge clk);
      vectors++;
      if (r4 != 4'd0 || z4 != 1'b1 || r32 != 32'd0 || z32 != 1'b1) begin
         misses++;
         $display("FAIL R7 reset idle result=%h/%h zero=%b/%b expected=0/0 1/1",
                  r4, r32, z4, z32);
      end
      rst_n = 1'b1;

      // exhaustive 4-bit sweep over all codes: R1..R9, including slt overflow (R5)
      for (int c = 0; c < 16; c++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               apply4(4'(a), 4'(b), 4'(c));

      // 32-bit edge operands, all codes
      edges[0] = 32'h0000_0000; edges[1] = 32'h0000_0001;
      edges[2] = 32'h7FFF_FFFF; edges[3] = 32'h8000_0000;
      edges[4] = 32'hFFFF_FFFF; edges[5] = 32'h5555_5555;
      edges[6] = 32'hAAAA_AAAA; edges[7] = 32'h8000_0001;
      for (int c = 0; c < 16; c++)
         for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
               apply32(edges[i], edges[j], 4'(c));

      // 32-bit pseudo-random pairs, all codes
      lfsr = 32'hACE1_2468;
      for (int k = 0; k < 300; k++) begin
         logic [31:0] ra, rb;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         ra = lfsr;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         rb = lfsr ^ 32'h3C5A_96F0;
         for (int c = 0; c < 16; c++)
            apply32(ra, rb, 4'(c));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         misses++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

endmodule